// File: doc/BRIEF.md
# Serial Register Port

This block lets a host reach a small bank of 8-bit registers over a few wires: a 3-bit register select, a data line split into pad-side input, output and output-enable, an active-low read strobe, an active-low write strobe and a host-driven shift clock. Three of the registers (two control words and a tone word) can be read and written, and their contents drive the rest of the chip through output ports. The fourth register holds a status word that the chip's detect logic supplies on every clock. The host can read it but cannot change it.

Every host pin passes through a configurable synchronizer into the block's own clock domain, and edges are found by comparing successive synchronized samples. A read starts when the read strobe falls. The selected register is copied into an output shifter and its bit 0 goes onto the data line at once. Each falling edge of the shift clock then brings the next bit forward. A write collects bits on rising shift-clock edges, least significant first. The collected byte is stored when the write strobe rises again.

Top module: `sra_serial_port`

## Requirements
- R1: After reset, both control outputs and the tone output read 0x00, and the data output enable is low.
- R2: The data output enable goes high only while the read strobe is held low, and it is low at all other times, including while a write is being shifted.
- R3: When the read strobe falls, bit 0 of the selected register appears on the data output. Each later falling edge of the shift clock moves the output to the next higher bit, so bit 7 is present after the seventh falling edge.
- R4: While the read strobe is high, each rising edge of the shift clock takes in one data bit, least significant first. A rising edge of the write strobe then stores the byte into the selected register. Address 0 is control word A, address 1 is control word B, and address 3 is the tone word. Each of these is visible on its output port.
- R5: Address 2 reads back the current value of the detect input. A write to address 2 changes no register.
- R6: Addresses 4 to 7 read back 0x00, and a write to any of them changes no register.
- R7: If the read strobe is low at any time between the fall and the rise of the write strobe, no register is written.
- R8: If more than eight rising shift-clock edges come before the write strobe, the stored byte is made of the last eight bits shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Register select from host |
| sclk_i | input | 1 | Host shift clock |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| sdata_i | input | 1 | Serial data from host (pad input side) |
| sdata_o | output | 1 | Serial data to host (pad output side) |
| sdata_oe_o | output | 1 | Pad output enable for the data line |
| detect_i | input | 8 | Status word from detect logic |
| ctrl_a_o | output | 8 | Control word A contents |
| ctrl_b_o | output | 8 | Control word B contents |
| tone_o | output | 8 | Tone word contents |

## Verification
The hardest case to reach from the ports is two strobes that overlap. The bench builds the overlap in both orders: first the read strobe is dropped around a complete write-strobe pulse, then a short read pulse is placed inside a write-strobe low period. In both cases it reads the target register back to confirm that nothing was stored, and then a clean write to that register must succeed. An over-long shift of eleven bits checks that only the last eight bits count. A sweep writes every address with several bit patterns and reads each one back bit by bit while the detect word changes.

// File: rtl/sra_pkg.sv
package sra_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL_A = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL_B = 3'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] A_TONE   = 3'd3;

    typedef struct packed {
        logic              sclk;
        logic              rd_n;
        logic              wr_n;
        logic              din;
        logic [ADDR_W-1:0] addr;
    } host_t;

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic rd_fall;
        logic wr_fall;
        logic wr_rise;
    } edges_t;

    function automatic host_t host_idle();
        host_t h;
        h.sclk = 1'b0;
        h.rd_n = 1'b1;
        h.wr_n = 1'b1;
        h.din  = 1'b0;
        h.addr = '0;
        return h;
    endfunction

    function automatic logic host_writable(logic [ADDR_W-1:0] a);
        return (a == A_CTRL_A) || (a == A_CTRL_B) || (a == A_TONE);
    endfunction

endpackage

// File: rtl/sra_sync.sv
module sra_sync
    import sra_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  host_t raw,
    output host_t synced
);
    host_t chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= host_idle();
                    else     chain[i] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= host_idle();
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/sra_edges.sv
module sra_edges
    import sra_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  host_t  cur,
    output edges_t edg
);
    host_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= host_idle();
        else     prev_q <= cur;
    end

    always_comb begin
        edg.sclk_rise = !prev_q.sclk &&  cur.sclk;
        edg.sclk_fall =  prev_q.sclk && !cur.sclk;
        edg.rd_fall   =  prev_q.rd_n && !cur.rd_n;
        edg.wr_fall   =  prev_q.wr_n && !cur.wr_n;
        edg.wr_rise   = !prev_q.wr_n &&  cur.wr_n;
    end
endmodule

// File: rtl/sra_shifter.sv
module sra_shifter
    import sra_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  edges_t       edg,
    input  host_t        cur,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] wdata,
    output logic         sout,
    output logic         soe
);
    logic [W-1:0] rd_sh_q;
    logic [W-1:0] wr_sh_q;
    logic         active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sh_q  <= '0;
            active_q <= 1'b0;
        end else if (cur.rd_n) begin
            active_q <= 1'b0;
        end else if (edg.rd_fall) begin
            rd_sh_q  <= rdata;
            active_q <= 1'b1;
        end else if (edg.sclk_fall) begin
            rd_sh_q  <= rd_sh_q >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            wr_sh_q <= '0;
        else if (cur.rd_n && edg.sclk_rise)
            wr_sh_q <= {cur.din, wr_sh_q[W-1:1]};
    end

    assign wdata = wr_sh_q;
    assign sout  = rd_sh_q[0];
    assign soe   = active_q;
endmodule

// File: rtl/sra_regfile.sv
module sra_regfile
    import sra_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  edges_t       edg,
    input  host_t        cur,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] detect,
    output logic [W-1:0] rdata,
    output logic [W-1:0] ctrl_a,
    output logic [W-1:0] ctrl_b,
    output logic [W-1:0] tone
);
    logic         clash_q;
    logic         commit;
    logic [W-1:0] ctrl_a_q, ctrl_b_q, tone_q, status_q;

    always_ff @(posedge clk) begin
        if (rst)
            clash_q <= 1'b0;
        else if (edg.wr_fall)
            clash_q <= !cur.rd_n;
        else if (!cur.wr_n && !cur.rd_n)
            clash_q <= 1'b1;
    end

    assign commit = edg.wr_rise && !clash_q && cur.rd_n && host_writable(cur.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_a_q <= '0;
            ctrl_b_q <= '0;
            tone_q   <= '0;
            status_q <= '0;
        end else begin
            status_q <= detect;
            if (commit) begin
                case (cur.addr)
                    A_CTRL_A: ctrl_a_q <= wdata;
                    A_CTRL_B: ctrl_b_q <= wdata;
                    A_TONE:   tone_q   <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (cur.addr)
            A_CTRL_A: rdata = ctrl_a_q;
            A_CTRL_B: rdata = ctrl_b_q;
            A_STATUS: rdata = status_q;
            A_TONE:   rdata = tone_q;
            default:  rdata = '0;
        endcase
    end

    assign ctrl_a = ctrl_a_q;
    assign ctrl_b = ctrl_b_q;
    assign tone   = tone_q;
endmodule

// File: rtl/sra_serial_port.sv
module sra_serial_port
    import sra_pkg::*;
#(
    parameter int DATA_W      = REG_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sclk_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic              sdata_i,
    output logic              sdata_o,
    output logic              sdata_oe_o,
    input  logic [DATA_W-1:0] detect_i,
    output logic [DATA_W-1:0] ctrl_a_o,
    output logic [DATA_W-1:0] ctrl_b_o,
    output logic [DATA_W-1:0] tone_o
);
    host_t        host_raw;
    host_t        host_s;
    edges_t       edg;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] wdata;

    always_comb begin
        host_raw.sclk = sclk_i;
        host_raw.rd_n = rd_n_i;
        host_raw.wr_n = wr_n_i;
        host_raw.din  = sdata_i;
        host_raw.addr = addr_i;
    end

    sra_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (host_raw),
        .synced (host_s)
    );

    sra_edges u_edges (
        .clk (clk),
        .rst (rst),
        .cur (host_s),
        .edg (edg)
    );

    sra_shifter #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .edg   (edg),
        .cur   (host_s),
        .rdata (rdata),
        .wdata (wdata),
        .sout  (sdata_o),
        .soe   (sdata_oe_o)
    );

    sra_regfile #(.W(DATA_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .edg    (edg),
        .cur    (host_s),
        .wdata  (wdata),
        .detect (detect_i),
        .rdata  (rdata),
        .ctrl_a (ctrl_a_o),
        .ctrl_b (ctrl_b_o),
        .tone   (tone_o)
    );
endmodule

// File: rtl/sra_serial_port_chk.sv
module sra_serial_port_chk
    import sra_pkg::*;
#(
    parameter int W = REG_W
) (
    input logic         clk,
    input logic         rst,
    input host_t        host_s,
    input edges_t       edg,
    input logic         sdata_o,
    input logic         sdata_oe_o,
    input logic [W-1:0] ctrl_a_o,
    input logic [W-1:0] ctrl_b_o,
    input logic [W-1:0] tone_o
);
    // R2
    oe_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
        sdata_oe_o |-> !$past(host_s.rd_n));

    // R3
    rd_bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sdata_oe_o && $past(sdata_oe_o) && !$past(edg.sclk_fall)) |-> $stable(sdata_o));

    // R4
    ctrl_a_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_a_o) |-> $past(edg.wr_rise));

    // R4
    ctrl_b_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_b_o) |-> ($past(edg.wr_rise) && $past(host_s.addr) == A_CTRL_B));

    // R6
    ctrl_a_decode_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_a_o) |-> ($past(host_s.addr) == A_CTRL_A));

    // R7
    tone_no_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tone_o) |-> ($past(host_s.rd_n) && $past(edg.wr_rise)));
endmodule

bind sra_serial_port sra_serial_port_chk #(.W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_s     (host_s),
    .edg        (edg),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o),
    .ctrl_a_o   (ctrl_a_o),
    .ctrl_b_o   (ctrl_b_o),
    .tone_o     (tone_o)
);

// File: tb/sra_serial_port_test.sv
module sra_serial_port_test;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       sclk = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       din = 1'b0;
    logic       sdata_o, sdata_oe_o;
    logic [7:0] detect = 8'h96;
    logic [7:0] ctrl_a_o, ctrl_b_o, tone_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [7:0] model [8];

    always #5 clk = ~clk;

    sra_serial_port uut (
        .clk(clk), .rst(rst), .addr_i(addr), .sclk_i(sclk), .rd_n_i(rd_n),
        .wr_n_i(wr_n), .sdata_i(din), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
        .detect_i(detect), .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o), .tone_o(tone_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit writable(input int a);
        return (a == 0) || (a == 1) || (a == 3);
    endfunction

    function automatic logic [7:0] expect_read(input int a);
        if (writable(a)) return model[a];
        if (a == 2)      return detect;
        return 8'h00;
    endfunction

    task automatic shift_in(input logic [15:0] v, input int n);
        rd_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            din = v[i];
            tick(HALF);
            sclk = 1'b1;
            tick(HALF);
            check("R2 oe during write shift", {7'd0, sdata_oe_o}, 8'h00);
            sclk = 1'b0;
        end
    endtask

    task automatic pulse_wr();
        wr_n = 1'b0;
        tick(HALF);
        wr_n = 1'b1;
        tick(HALF);
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        addr = 3'(a);
        shift_in({8'h00, d}, 8);
        pulse_wr();
    endtask

    task automatic host_read(input int a, output logic [7:0] v);
        logic oe_all;
        addr = 3'(a);
        rd_n = 1'b0;
        tick(HALF);
        oe_all = sdata_oe_o;
        v[0] = sdata_o;
        for (int i = 1; i < 8; i++) begin
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
            tick(HALF);
            v[i] = sdata_o;
            oe_all = oe_all & sdata_oe_o;
        end
        check("R2 oe while reading", {7'd0, oe_all}, 8'h01);
        rd_n = 1'b1;
        tick(HALF);
        check("R2 oe after read", {7'd0, sdata_oe_o}, 8'h00);
    endtask

    task automatic check_ports(input string req);
        check({req, " ctrl_a port"}, ctrl_a_o, model[0]);
        check({req, " ctrl_b port"}, ctrl_b_o, model[1]);
        check({req, " tone port"},   tone_o,   model[3]);
    endtask

    task automatic read_all();
        logic [7:0] v;
        for (int a = 0; a < 8; a++) begin
            host_read(a, v);
            if (a == 2)       check("R5 detect readback", v, expect_read(a));
            else if (a > 3)   check("R6 unused readback", v, expect_read(a));
            else              check("R3 R4 register readback", v, expect_read(a));
        end
    endtask

    initial begin
        logic [7:0] pats [4];
        logic [7:0] d;
        logic [15:0] longv;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
        for (int a = 0; a < 8; a++) model[a] = 8'h00;

        tick(4);
        rst = 1'b0;
        tick(2);
        // R1 reset state
        check("R1 ctrl_a reset", ctrl_a_o, 8'h00);
        check("R1 ctrl_b reset", ctrl_b_o, 8'h00);
        check("R1 tone reset", tone_o, 8'h00);
        check("R1 oe reset", {7'd0, sdata_oe_o}, 8'h00);
        read_all();

        // R4 R5 R6 sweep of every address with several patterns
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 8; a++) begin
                d = pats[p] ^ 8'(a * 29);
                host_write(a, d);
                if (writable(a)) model[a] = d;
                if (a == 2)      check_ports("R5 write to detect address");
                else if (a > 3)  check_ports("R6 write to unused address");
                else             check_ports("R4 write commit");
            end
            detect = pats[p] + 8'h11;
            tick(4);
            read_all();
        end

        // R8 over-long shift keeps the last eight bits
        longv = 16'h06B5;
        addr = 3'd1;
        shift_in(longv, 11);
        pulse_wr();
        model[1] = 8'((longv >> 3) & 16'h00FF);
        check_ports("R8 last eight bits");

        // R7 read strobe held around the write pulse
        addr = 3'd3;
        shift_in(16'h0042, 8);
        rd_n = 1'b0;
        tick(HALF);
        pulse_wr();
        rd_n = 1'b1;
        tick(HALF);
        check_ports("R7 rd around wr");

        // R7 short read pulse inside the write pulse
        addr = 3'd0;
        shift_in(16'h00C9, 8);
        wr_n = 1'b0;
        tick(HALF);
        rd_n = 1'b0;
        tick(HALF);
        rd_n = 1'b1;
        tick(HALF);
        wr_n = 1'b1;
        tick(HALF);
        check_ports("R7 rd inside wr");

        // R7 a clean write afterwards still works
        host_write(3, 8'h42);
        model[3] = 8'h42;
        check_ports("R7 clean write after clash");
        read_all();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule